// File: doc/BRIEF.md
# Digital PLL Operating-Mode Sequencer

This block is the control state machine of a digital PLL clock synthesizer. It takes the design from reset to steady operation. It reads status flags from the analog loops (secondary PLL lock, primary PLL lock), a validity bit for each reference input, and a phase-lock-detect flag with its check-period strobe. From these it drives three controls: a request that holds the primary VCO at its centre frequency, an enable for the primary analog loop, and an enable for the digital loop. It also reports a mode code, with a one-cycle pulse each time that code changes.

Start-up depends on the cascade setting. When the secondary PLL takes its reference from the primary VCO, the VCO is held at its centre until the secondary loop reports lock. Without cascading, the primary loop is released at once. Once the primary loop locks to the crystal, the block runs free. A valid reference starts lock acquisition. Holdover is entered only when no reference at all remains valid. A reference that stays valid for a programmable qualification time brings the block back to acquisition.

While the digital loop is active and DCO operation is enabled, increment and decrement strobes move a signed feedback-divider fractional offset by a programmed step. The offset is clamped to programmable signed limits.

Top module: `dpll_mode_seq`

## Requirements
- R1: While rst_n is low: mode is 0, mode_chg is 0, frac_ofs is 0, pri_pll_en is 0, dig_loop_en is 0, and vco_hold equals cfg_cascade.
- R2: With cfg_cascade=1, vco_hold stays 1 and pri_pll_en stays 0 until sec_lock is seen high at a clock edge. From the cycle after that edge, vco_hold is 0 and pri_pll_en is 1.
- R3: With cfg_cascade=0, vco_hold is never 1 and pri_pll_en rises one cycle after reset release, whatever sec_lock is.
- R4: In init with pri_pll_en=1, a high pri_lock moves mode to free-run (code 1) on the next cycle.
- R5: In free-run, any set bit of ref_valid (bit i is reference i) moves mode to acquiring (code 2) on the next cycle. With no bit set, mode stays 1.
- R6: In acquiring, mode becomes locked (code 3) in the cycle after the lock_periods-th consecutive chk_tick cycle on which phase_lock is 1. A chk_tick with phase_lock=0 restarts the count, and a lock_periods of 0 acts as 1.
- R7: Acquiring or locked moves to holdover (code 4) on the next cycle only when ref_valid is all zero. Losing some references while one remains valid keeps the mode.
- R8: In holdover, mode returns to acquiring in the cycle after requal_cycles consecutive cycles with at least one ref_valid bit set. A cycle with none set restarts the count, and 0 acts as 1.
- R9: With dig_loop_en=1 (modes 2 and 3) and cfg_dco_en=1, a dco_inc cycle adds dco_step to frac_ofs and a dco_dec cycle subtracts it. The new value shows on the next cycle.
- R10: frac_ofs does not change on a cycle where the mode is 0, 1 or 4, where cfg_dco_en=0, or where dco_inc and dco_dec are both high.
- R11: A step that would carry frac_ofs above dco_max or below dco_min leaves it at dco_max or dco_min instead of wrapping.
- R12: mode_chg is 1 in exactly those cycles whose mode differs from the mode of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cascade | input | 1 | Secondary PLL is fed from the primary VCO |
| cfg_dco_en | input | 1 | Enable frequency stepping |
| sec_lock | input | 1 | Secondary PLL lock flag |
| pri_lock | input | 1 | Primary PLL lock flag |
| ref_valid | input | NUM_REFS | Per-reference validity |
| phase_lock | input | 1 | Digital loop phase-lock-detect flag |
| chk_tick | input | 1 | Lock check period strobe |
| lock_periods | input | CNT_W | Consecutive good checks needed for lock |
| requal_cycles | input | CNT_W | Valid cycles needed to leave holdover |
| dco_inc | input | 1 | Step frequency up |
| dco_dec | input | 1 | Step frequency down |
| dco_step | input | STEP_W | Unsigned step size |
| dco_max | input | OFS_W | Signed upper offset limit |
| dco_min | input | OFS_W | Signed lower offset limit |
| vco_hold | output | 1 | Hold primary VCO at centre frequency |
| pri_pll_en | output | 1 | Enable primary analog loop |
| dig_loop_en | output | 1 | Digital loop active |
| mode | output | 3 | 0 init, 1 free-run, 2 acquiring, 3 locked, 4 holdover |
| mode_chg | output | 1 | One-cycle pulse on a mode change |
| frac_ofs | output | OFS_W | Signed fractional divider correction |

## Verification
The checker watches several properties on every cycle. Under cascade, the VCO hold is kept while the secondary loop is unlocked, and the primary loop stays off while the hold is up. The non-cascaded release comes one cycle after reset. Primary lock and a valid reference each advance the mode. Holdover is entered only after a cycle with every reference invalid, and loss of all references always leads there. The offset stays still whenever stepping is not allowed, and an upward step never passes the upper limit. The mode-change pulse matches each mode change. Only the bench scenarios can show the counted behaviours: a bad check period restarting the lock count, a dropped reference restarting the holdover qualification, the exact step arithmetic, and clamping at the lower limit.

// File: rtl/dpll_seq_pkg.sv
package dpll_seq_pkg;

    typedef enum logic [2:0] {
        ST_CTR_HOLD = 3'd0,
        ST_PRI_WAIT = 3'd1,
        ST_FREE     = 3'd2,
        ST_ACQ      = 3'd3,
        ST_LOCK     = 3'd4,
        ST_HOLDOVER = 3'd5
    } seq_state_e;

    localparam int MODE_W = 3;
    localparam logic [MODE_W-1:0] MODE_INIT = 3'd0;
    localparam logic [MODE_W-1:0] MODE_FREE = 3'd1;
    localparam logic [MODE_W-1:0] MODE_ACQ  = 3'd2;
    localparam logic [MODE_W-1:0] MODE_LOCK = 3'd3;
    localparam logic [MODE_W-1:0] MODE_HOLD = 3'd4;

    function automatic logic [MODE_W-1:0] mode_of(seq_state_e s);
        case (s)
            ST_FREE:     return MODE_FREE;
            ST_ACQ:      return MODE_ACQ;
            ST_LOCK:     return MODE_LOCK;
            ST_HOLDOVER: return MODE_HOLD;
            default:     return MODE_INIT;
        endcase
    endfunction

endpackage

// File: rtl/dpll_seq_fsm.sv
module dpll_seq_fsm
    import dpll_seq_pkg::*;
#(
    parameter int NUM_REFS = 4,
    parameter int CNT_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_cascade,
    input  logic                sec_lock,
    input  logic                pri_lock,
    input  logic [NUM_REFS-1:0] ref_valid,
    input  logic                phase_lock,
    input  logic                chk_tick,
    input  logic [CNT_W-1:0]    lock_periods,
    input  logic [CNT_W-1:0]    requal_cycles,
    output seq_state_e          state,
    output logic                mode_chg
);

    localparam int CX_W = CNT_W + 1;

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             chg;
    } fsm_t;

    fsm_t q, d;

    logic            any_ref;
    logic [CX_W-1:0] cnt_nx;
    logic [CX_W-1:0] lock_tgt;
    logic [CX_W-1:0] qual_tgt;

    always_comb begin
        any_ref  = |ref_valid;
        cnt_nx   = {1'b0, q.cnt} + 1'b1;
        lock_tgt = (lock_periods  == '0) ? CX_W'(1) : {1'b0, lock_periods};
        qual_tgt = (requal_cycles == '0) ? CX_W'(1) : {1'b0, requal_cycles};

        d     = q;
        d.chg = 1'b0;
        case (q.state)
            ST_CTR_HOLD: begin
                if (!cfg_cascade || sec_lock) d.state = ST_PRI_WAIT;
            end
            ST_PRI_WAIT: begin
                if (pri_lock) d.state = ST_FREE;
            end
            ST_FREE: begin
                if (any_ref) begin
                    d.state = ST_ACQ;
                    d.cnt   = '0;
                end
            end
            ST_ACQ: begin
                if (!any_ref) begin
                    d.state = ST_HOLDOVER;
                    d.cnt   = '0;
                end else if (chk_tick) begin
                    if (!phase_lock) begin
                        d.cnt = '0;
                    end else if (cnt_nx >= lock_tgt) begin
                        d.state = ST_LOCK;
                        d.cnt   = '0;
                    end else begin
                        d.cnt = cnt_nx[CNT_W-1:0];
                    end
                end
            end
            ST_LOCK: begin
                if (!any_ref) begin
                    d.state = ST_HOLDOVER;
                    d.cnt   = '0;
                end
            end
            ST_HOLDOVER: begin
                if (!any_ref) begin
                    d.cnt = '0;
                end else if (cnt_nx >= qual_tgt) begin
                    d.state = ST_ACQ;
                    d.cnt   = '0;
                end else begin
                    d.cnt = cnt_nx[CNT_W-1:0];
                end
            end
            default: d.state = ST_CTR_HOLD;
        endcase
        d.chg = (mode_of(d.state) != mode_of(q.state));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state <= ST_CTR_HOLD;
            q.cnt   <= '0;
            q.chg   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign state    = q.state;
    assign mode_chg = q.chg;

endmodule

// File: rtl/dpll_seq_dco.sv
module dpll_seq_dco #(
    parameter int STEP_W = 16,
    parameter int OFS_W  = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    apply_en,
    input  logic                    inc,
    input  logic                    dec,
    input  logic [STEP_W-1:0]       step,
    input  logic signed [OFS_W-1:0] lim_hi,
    input  logic signed [OFS_W-1:0] lim_lo,
    output logic signed [OFS_W-1:0] ofs
);

    localparam int BASE_W = (STEP_W > OFS_W) ? STEP_W : OFS_W;
    localparam int SUM_W  = BASE_W + 2;

    typedef struct packed {
        logic signed [OFS_W-1:0] ofs;
    } dco_t;

    dco_t q, d;

    logic signed [SUM_W-1:0] cur_x;
    logic signed [SUM_W-1:0] stp_x;
    logic signed [SUM_W-1:0] sum_x;
    logic signed [SUM_W-1:0] hi_x;
    logic signed [SUM_W-1:0] lo_x;

    always_comb begin
        cur_x = SUM_W'(q.ofs);
        stp_x = $signed({{(SUM_W-STEP_W){1'b0}}, step});
        hi_x  = SUM_W'(lim_hi);
        lo_x  = SUM_W'(lim_lo);
        sum_x = inc ? (cur_x + stp_x) : (cur_x - stp_x);

        d = q;
        if (apply_en && (inc ^ dec)) begin
            if (sum_x > hi_x)      d.ofs = lim_hi;
            else if (sum_x < lo_x) d.ofs = lim_lo;
            else                   d.ofs = sum_x[OFS_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q.ofs <= '0;
        else        q <= d;
    end

    assign ofs = q.ofs;

endmodule

// File: rtl/dpll_mode_seq.sv
module dpll_mode_seq
    import dpll_seq_pkg::*;
#(
    parameter int NUM_REFS = 4,
    parameter int CNT_W    = 8,
    parameter int STEP_W   = 16,
    parameter int OFS_W    = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_cascade,
    input  logic                    cfg_dco_en,
    input  logic                    sec_lock,
    input  logic                    pri_lock,
    input  logic [NUM_REFS-1:0]     ref_valid,
    input  logic                    phase_lock,
    input  logic                    chk_tick,
    input  logic [CNT_W-1:0]        lock_periods,
    input  logic [CNT_W-1:0]        requal_cycles,
    input  logic                    dco_inc,
    input  logic                    dco_dec,
    input  logic [STEP_W-1:0]       dco_step,
    input  logic signed [OFS_W-1:0] dco_max,
    input  logic signed [OFS_W-1:0] dco_min,
    output logic                    vco_hold,
    output logic                    pri_pll_en,
    output logic                    dig_loop_en,
    output logic [2:0]              mode,
    output logic                    mode_chg,
    output logic signed [OFS_W-1:0] frac_ofs
);

    seq_state_e st;
    logic       step_ok;

    dpll_seq_fsm #(
        .NUM_REFS (NUM_REFS),
        .CNT_W    (CNT_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_cascade   (cfg_cascade),
        .sec_lock      (sec_lock),
        .pri_lock      (pri_lock),
        .ref_valid     (ref_valid),
        .phase_lock    (phase_lock),
        .chk_tick      (chk_tick),
        .lock_periods  (lock_periods),
        .requal_cycles (requal_cycles),
        .state         (st),
        .mode_chg      (mode_chg)
    );

    always_comb begin
        vco_hold    = (st == ST_CTR_HOLD) && cfg_cascade;
        pri_pll_en  = (st != ST_CTR_HOLD);
        dig_loop_en = (st == ST_ACQ) || (st == ST_LOCK);
        mode        = mode_of(st);
        step_ok     = dig_loop_en && cfg_dco_en;
    end

    dpll_seq_dco #(
        .STEP_W (STEP_W),
        .OFS_W  (OFS_W)
    ) u_dco (
        .clk      (clk),
        .rst_n    (rst_n),
        .apply_en (step_ok),
        .inc      (dco_inc),
        .dec      (dco_dec),
        .step     (dco_step),
        .lim_hi   (dco_max),
        .lim_lo   (dco_min),
        .ofs      (frac_ofs)
    );

endmodule

// File: rtl/dpll_mode_seq_chk.sv
module dpll_mode_seq_chk #(
    parameter int NUM_REFS = 4,
    parameter int OFS_W    = 24
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cfg_cascade,
    input logic                    cfg_dco_en,
    input logic                    sec_lock,
    input logic                    pri_lock,
    input logic [NUM_REFS-1:0]     ref_valid,
    input logic                    dco_inc,
    input logic                    dco_dec,
    input logic signed [OFS_W-1:0] dco_max,
    input logic                    vco_hold,
    input logic                    pri_pll_en,
    input logic                    dig_loop_en,
    input logic [2:0]              mode,
    input logic                    mode_chg,
    input logic signed [OFS_W-1:0] frac_ofs
);

    // R2
    hold_blocks_pri_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vco_hold |-> !pri_pll_en);

    // R2
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vco_hold && cfg_cascade && !sec_lock) |=> vco_hold);

    // R3
    nocasc_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_cascade && mode == 3'd0 && !pri_pll_en) |=> pri_pll_en);

    // R4
    pri_lock_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0 && pri_pll_en && pri_lock) |=> (mode == 3'd1));

    // R5
    free_to_acq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd1 && ref_valid != '0) |=> (mode == 3'd2));

    // R7
    hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd4 && $past(mode) != 3'd4) |-> ($past(ref_valid) == '0));

    // R7
    loss_to_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_loop_en && ref_valid == '0) |=> (mode == 3'd4));

    // R10
    dco_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dig_loop_en || !cfg_dco_en || (dco_inc == dco_dec)) |=> $stable(frac_ofs));

    // R11
    dco_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_loop_en && cfg_dco_en && dco_inc && !dco_dec)
        |=> ($signed(frac_ofs) <= $signed($past(dco_max))));

    // R12
    chg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg == (mode != $past(mode)));

endmodule

bind dpll_mode_seq dpll_mode_seq_chk #(
    .NUM_REFS (NUM_REFS),
    .OFS_W    (OFS_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_cascade (cfg_cascade),
    .cfg_dco_en  (cfg_dco_en),
    .sec_lock    (sec_lock),
    .pri_lock    (pri_lock),
    .ref_valid   (ref_valid),
    .dco_inc     (dco_inc),
    .dco_dec     (dco_dec),
    .dco_max     (dco_max),
    .vco_hold    (vco_hold),
    .pri_pll_en  (pri_pll_en),
    .dig_loop_en (dig_loop_en),
    .mode        (mode),
    .mode_chg    (mode_chg),
    .frac_ofs    (frac_ofs)
);

// File: tb/dpll_mode_seq_test.sv
`timescale 1ns/1ps
module dpll_mode_seq_test;

    localparam int NR = 4;
    localparam int CW = 8;
    localparam int SW = 16;
    localparam int OW = 24;

    localparam logic [2:0] M_INIT = 3'd0;
    localparam logic [2:0] M_FREE = 3'd1;
    localparam logic [2:0] M_ACQ  = 3'd2;
    localparam logic [2:0] M_LOCK = 3'd3;
    localparam logic [2:0] M_HOLD = 3'd4;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 cfg_cascade, cfg_dco_en, sec_lock, pri_lock;
    logic [NR-1:0]        ref_valid;
    logic                 phase_lock, chk_tick;
    logic [CW-1:0]        lock_periods, requal_cycles;
    logic                 dco_inc, dco_dec;
    logic [SW-1:0]        dco_step;
    logic signed [OW-1:0] dco_max, dco_min;
    logic                 vco_hold, pri_pll_en, dig_loop_en, mode_chg;
    logic [2:0]           mode;
    logic signed [OW-1:0] frac_ofs;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dpll_mode_seq #(.NUM_REFS(NR), .CNT_W(CW), .STEP_W(SW), .OFS_W(OW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_cascade(cfg_cascade), .cfg_dco_en(cfg_dco_en),
        .sec_lock(sec_lock), .pri_lock(pri_lock), .ref_valid(ref_valid),
        .phase_lock(phase_lock), .chk_tick(chk_tick), .lock_periods(lock_periods),
        .requal_cycles(requal_cycles), .dco_inc(dco_inc), .dco_dec(dco_dec),
        .dco_step(dco_step), .dco_max(dco_max), .dco_min(dco_min),
        .vco_hold(vco_hold), .pri_pll_en(pri_pll_en), .dig_loop_en(dig_loop_en),
        .mode(mode), .mode_chg(mode_chg), .frac_ofs(frac_ofs)
    );

    // kind: 0 -> R9 arithmetic, 1 -> R10 ignored, 2 -> R11 clamp
    typedef struct packed {
        logic                 en;
        logic                 inc;
        logic                 dec;
        logic [SW-1:0]        step;
        logic signed [OW-1:0] exp;
        logic [1:0]           kind;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 1'b0, 16'd30,  24'sd30,  2'd0},
        '{1'b1, 1'b1, 1'b0, 16'd30,  24'sd60,  2'd0},
        '{1'b1, 1'b0, 1'b1, 16'd10,  24'sd50,  2'd0},
        '{1'b1, 1'b1, 1'b1, 16'd5,   24'sd50,  2'd1},
        '{1'b0, 1'b1, 1'b0, 16'd7,   24'sd50,  2'd1},
        '{1'b1, 1'b1, 1'b0, 16'd70,  24'sd100, 2'd2},
        '{1'b1, 1'b1, 1'b0, 16'd1,   24'sd100, 2'd2},
        '{1'b1, 1'b0, 1'b1, 16'd200, -24'sd50, 2'd2},
        '{1'b1, 1'b0, 1'b1, 16'd1,   -24'sd50, 2'd2},
        '{1'b1, 1'b1, 1'b0, 16'd20,  -24'sd30, 2'd0}
    };

    function automatic string kind_tag(logic [1:0] k);
        case (k)
            2'd0:    return "R9";
            2'd1:    return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic pulse(logic good);
        chk_tick   = 1'b1;
        phase_lock = good;
        step();
        chk_tick   = 1'b0;
    endtask

    task automatic apply_reset(logic casc);
        rst_n       = 1'b0;
        cfg_cascade = casc;
        cfg_dco_en  = 1'b1;
        sec_lock    = 1'b0;
        pri_lock    = 1'b0;
        ref_valid   = '0;
        phase_lock  = 1'b0;
        chk_tick    = 1'b0;
        dco_inc     = 1'b0;
        dco_dec     = 1'b0;
        dco_step    = '0;
        repeat (3) step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        lock_periods  = 8'd3;
        requal_cycles = 8'd4;
        dco_max       = 24'sd100;
        dco_min       = -24'sd50;

        // ---- cascaded start-up ----
        apply_reset(1'b1);
        check("R1 mode", int'(mode), int'(M_INIT));
        check("R1 vco_hold", int'(vco_hold), 1);
        check("R1 pri_pll_en", int'(pri_pll_en), 0);
        check("R1 dig_loop_en", int'(dig_loop_en), 0);
        check("R1 mode_chg", int'(mode_chg), 0);
        check("R1 frac_ofs", int'(frac_ofs), 0);

        rst_n = 1'b1;
        repeat (3) step();
        check("R2 hold kept", int'(vco_hold), 1);
        check("R2 pri off", int'(pri_pll_en), 0);
        sec_lock = 1'b1;
        step();
        check("R2 hold released", int'(vco_hold), 0);
        check("R2 pri on", int'(pri_pll_en), 1);
        check("R2 still init", int'(mode), int'(M_INIT));

        // R10: stepping in init is ignored
        dco_inc = 1'b1; dco_step = 16'd9;
        step();
        dco_inc = 1'b0;
        check("R10 init step ignored", int'(frac_ofs), 0);

        pri_lock = 1'b1;
        step();
        check("R4 free-run", int'(mode), int'(M_FREE));
        check("R12 pulse on change", int'(mode_chg), 1);
        step();
        check("R12 pulse one cycle", int'(mode_chg), 0);
        check("R5 stays free with no ref", int'(mode), int'(M_FREE));

        dco_dec = 1'b1; dco_step = 16'd9;
        step();
        dco_dec = 1'b0;
        check("R10 free-run step ignored", int'(frac_ofs), 0);

        ref_valid = 4'b0010;
        step();
        check("R5 acquiring", int'(mode), int'(M_ACQ));

        // ---- R6 lock qualification ----
        pulse(1'b1);
        pulse(1'b1);
        pulse(1'b0);
        check("R6 bad period restarts", int'(mode), int'(M_ACQ));
        pulse(1'b1);
        pulse(1'b1);
        step();
        check("R6 two good not enough", int'(mode), int'(M_ACQ));
        pulse(1'b1);
        check("R6 locked", int'(mode), int'(M_LOCK));
        check("R12 pulse on lock", int'(mode_chg), 1);

        // ---- DCO vector table, in locked mode ----
        for (int i = 0; i < NV; i++) begin
            cfg_dco_en = VECS[i].en;
            dco_inc    = VECS[i].inc;
            dco_dec    = VECS[i].dec;
            dco_step   = VECS[i].step;
            step();
            dco_inc = 1'b0;
            dco_dec = 1'b0;
            cfg_dco_en = 1'b1;
            check(kind_tag(VECS[i].kind), int'(frac_ofs), int'(VECS[i].exp));
        end

        // ---- R7 partial loss ----
        ref_valid = 4'b0011;
        step();
        ref_valid = 4'b0001;
        step();
        check("R7 partial loss keeps lock", int'(mode), int'(M_LOCK));
        ref_valid = 4'b0000;
        step();
        check("R7 total loss holdover", int'(mode), int'(M_HOLD));
        check("R12 pulse on holdover", int'(mode_chg), 1);

        dco_inc = 1'b1; dco_step = 16'd5;
        step();
        dco_inc = 1'b0;
        check("R10 holdover step ignored", int'(frac_ofs), -30);

        // ---- R8 requalification (4 cycles) ----
        ref_valid = 4'b1000;
        step();
        step();
        ref_valid = 4'b0000;
        step();
        ref_valid = 4'b0100;
        step();
        step();
        step();
        check("R8 restart after drop", int'(mode), int'(M_HOLD));
        step();
        check("R8 back to acquiring", int'(mode), int'(M_ACQ));

        // ---- non-cascaded start-up ----
        apply_reset(1'b0);
        check("R1 no hold non-cascaded", int'(vco_hold), 0);
        check("R1 mode after reset", int'(mode), int'(M_INIT));
        check("R1 offset cleared", int'(frac_ofs), 0);
        rst_n = 1'b1;
        step();
        check("R3 pri released", int'(pri_pll_en), 1);
        check("R3 no hold", int'(vco_hold), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule